// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Path

This controller gathers 21 interrupt request lines and turns them into two CPU inputs: a maskable IRQ line and a non-maskable NMI line. Lines 0 to 7 are intended for requests from package pins and lines 8 to 20 for on-chip peripherals. The controller treats all 21 alike. Each request passes through one capture flop and then sets a bit in a raw pending register. One cycle later, a fixed-priority picker moves the winning unmasked IRQ-mode source into an arbitrated pending register. Only one bit of that register is ever set, and any set bit raises IRQ.

One source can be given the NMI role. Its raw pending bit drives the NMI line directly. It is never masked and never arbitrated. A small register bus with four word addresses gives software access to the mode, mask and both pending registers. An interrupt handler clears the raw pending bit first and then the arbitrated bit, each by writing a one.

Top module: `vint_ctrl`

## Requirements
- R1: After reset, both pending registers read 0, the mask register reads all ones (every source masked), the mode register reads 0 (every source IRQ), and irq_o and nmi_o are low.
- R2: A request that is high at a rising edge is captured, and its bit in the raw pending register is set at the following edge. This happens whether or not the source is masked, and a one-cycle pulse is enough.
- R3: In the cycle after raw pending bits appear, if the arbitrated register is empty, it takes exactly one bit. That bit belongs to the lowest-index source that is pending, unmasked and in IRQ mode.
- R4: A masked source never sets its bit in the arbitrated register.
- R5: irq_o is high exactly when the arbitrated register is nonzero.
- R6: Writing a 1 to a bit of either pending register clears that bit, and writing a 0 leaves it unchanged. If a request is still high while its raw bit is being cleared, the raw bit stays set.
- R7: While the arbitrated register is nonzero, no other source enters it. In the cycle after it is cleared, the highest-priority remaining eligible source is taken.
- R8: Mode bit 1 selects NMI. nmi_o is high whenever the raw pending bit of the NMI source is set, even if that source is masked. That source never enters the arbitrated register, and clearing its raw bit drops nmi_o.
- R9: If the mode register holds several ones, only the lowest-index one acts as NMI, and the others behave as IRQ sources. The mode register reads back exactly the value written.
- R10: Register addresses are: 0 for mode, 1 for mask (1 means masked), 2 for raw pending and 3 for arbitrated pending. Reads are combinational while bus_sel_i is high and bus_wr_i is low. Mode and mask writes take effect at the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 21 | Interrupt request lines, active high |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 21 | Write data |
| bus_rdata_o | output | 21 | Read data |
| irq_o | output | 1 | Maskable interrupt to CPU |
| nmi_o | output | 1 | Non-maskable interrupt to CPU |

## Verification
Suppose a request is driven before rising edge k. The capture flop takes it at edge k, the raw pending bit and nmi_o follow at edge k+1, and the arbitrated bit and irq_o follow at edge k+2. The bench drives on falling edges and waits exactly three rising edges before it samples at the next falling edge. Register writes land on the rising edge after they are driven. After the bench clears the arbitrated register, it checks that the register is empty at the next falling edge and that it holds the next winner one rising edge later. The bench predicts every winner with its own lowest-set-bit function.

// File: rtl/vint_pkg.sv
package vint_pkg;
  parameter int unsigned VINT_NSRC = 21;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_MASK = 2'd1,
    REG_SRC  = 2'd2,
    REG_INT  = 2'd3
  } vint_reg_e;
endpackage

// File: rtl/vint_rsync.sv
module vint_rsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n_s <= stage_q;
    end
  end
endmodule

// File: rtl/vint_capture.sv
module vint_capture #(
  parameter int unsigned N = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_i;
  end
endmodule

// File: rtl/vint_srcpnd.sv
module vint_srcpnd #(
  parameter int unsigned N = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_bits_i,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] pend_d;

  // set wins over a simultaneous clear
  always_comb begin
    pend_d = pend_q;
    if (clr_en_i) pend_d = pend_d & ~clr_bits_i;
    pend_d = pend_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/vint_pick.sv
module vint_pick #(
  parameter int unsigned N = 21
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] pick_o
);
  // lowest index wins
  for (genvar g = 0; g < N; g++) begin : g_bit
    if (g == 0) begin : g_first
      assign pick_o[g] = vec_i[g];
    end else begin : g_rest
      assign pick_o[g] = vec_i[g] & ~(|vec_i[g-1:0]);
    end
  end
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
  import vint_pkg::*;
#(
  parameter int unsigned NSRC = VINT_NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            bus_sel_i,
  input  logic            bus_wr_i,
  input  logic [1:0]      bus_addr_i,
  input  logic [NSRC-1:0] bus_wdata_i,
  output logic [NSRC-1:0] bus_rdata_o,
  output logic            irq_o,
  output logic            nmi_o
);
  logic            rst_n_s;
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] mode_q, mode_d;
  logic [NSRC-1:0] mask_q, mask_d;
  logic [NSRC-1:0] int_q, int_d;
  logic [NSRC-1:0] nmi_sel;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] win;
  logic            wr_mode, wr_mask, wr_src, wr_int;
  vint_reg_e       reg_sel;

  assign reg_sel = vint_reg_e'(bus_addr_i);
  assign wr_mode = bus_sel_i & bus_wr_i & (reg_sel == REG_MODE);
  assign wr_mask = bus_sel_i & bus_wr_i & (reg_sel == REG_MASK);
  assign wr_src  = bus_sel_i & bus_wr_i & (reg_sel == REG_SRC);
  assign wr_int  = bus_sel_i & bus_wr_i & (reg_sel == REG_INT);

  vint_rsync u_rsync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  vint_capture #(.N(NSRC)) u_capture (
    .clk   (clk),
    .rst_n (rst_n_s),
    .req_i (req_i),
    .req_q (req_q)
  );

  vint_srcpnd #(.N(NSRC)) u_srcpnd (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .set_i      (req_q),
    .clr_en_i   (wr_src),
    .clr_bits_i (bus_wdata_i),
    .pend_q     (src_q)
  );

  vint_pick #(.N(NSRC)) u_nmi_pick (
    .vec_i  (mode_q),
    .pick_o (nmi_sel)
  );

  assign elig = src_q & ~mask_q & ~nmi_sel;

  vint_pick #(.N(NSRC)) u_irq_pick (
    .vec_i  (elig),
    .pick_o (win)
  );

  always_comb begin
    mode_d = mode_q;
    mask_d = mask_q;
    if (wr_mode) mode_d = bus_wdata_i;
    if (wr_mask) mask_d = bus_wdata_i;
  end

  always_comb begin
    if (int_q == '0) begin
      int_d = win;
    end else begin
      int_d = int_q;
      if (wr_int) int_d = int_q & ~bus_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q <= '0;
      mask_q <= '1;
      int_q  <= '0;
    end else begin
      mode_q <= mode_d;
      mask_q <= mask_d;
      int_q  <= int_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_wr_i) begin
      unique case (reg_sel)
        REG_MODE: bus_rdata_o = mode_q;
        REG_MASK: bus_rdata_o = mask_q;
        REG_SRC:  bus_rdata_o = src_q;
        REG_INT:  bus_rdata_o = int_q;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |int_q;
  assign nmi_o = |(src_q & nmi_sel);
endmodule

// File: rtl/vint_chk.sv
module vint_chk #(
  parameter int unsigned N = 21
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_q,
  input logic [N-1:0] src_q,
  input logic [N-1:0] int_q,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] nmi_sel,
  input logic         irq_o,
  input logic         nmi_o
);
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != '0) |=> ((src_q & $past(req_q)) == $past(req_q)));

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_q));

  assert_no_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ((int_q & $past(mask_q)) == '0) &&
                     ((int_q & $past(src_q)) == int_q));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q != '0) |=> ((int_q & ~$past(int_q)) == '0));

  assert_single_nmi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> $onehot(nmi_sel));
endmodule

bind vint_ctrl vint_chk #(.N(NSRC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .req_q   (req_q),
  .src_q   (src_q),
  .int_q   (int_q),
  .mask_q  (mask_q),
  .nmi_sel (nmi_sel),
  .irq_o   (irq_o),
  .nmi_o   (nmi_o)
);

// File: tb/sim_vint_ctrl.sv
`timescale 1ns/1ps
module sim_vint_ctrl;
  localparam int N = 21;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         sel = 1'b0;
  logic         wr = 1'b0;
  logic [1:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq, nmi;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  vint_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .nmi_o(nmi)
  );

  function automatic logic [N-1:0] lowbit(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    addr = a; sel = 1'b1; wr = 1'b0;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic wrr(input logic [1:0] a, input logic [N-1:0] d);
    addr = a; wdata = d; sel = 1'b1; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] p);
    req = p;
    @(negedge clk);
    req = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    req = '0;
    repeat (2) @(negedge clk);
    wrr(2'd2, ALL);
    wrr(2'd3, ALL);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] d, pat, msk, md, ns;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 mode", d, '0);
    rd(2'd1, d); check("R1 mask", d, ALL);
    rd(2'd2, d); check("R1 src", d, '0);
    rd(2'd3, d); check("R1 int", d, '0);
    check("R1 irq", irq, 0); check("R1 nmi", nmi, 0);

    // R10 R2 R3 R5: priority between two sources
    wrr(2'd1, '0);
    rd(2'd1, d); check("R10 mask write", d, '0);
    pulse((N'(1) << 5) | (N'(1) << 12));
    rd(2'd2, d); check("R2 src", d, (N'(1) << 5) | (N'(1) << 12));
    rd(2'd3, d); check("R3 winner", d, N'(1) << 5);
    check("R5 irq high", irq, 1);

    // R6 R7: clear order, write-0 no effect, rearbitration
    wrr(2'd2, N'(1) << 5);
    rd(2'd2, d); check("R6 src cleared", d, N'(1) << 12);
    @(negedge clk);
    rd(2'd3, d); check("R7 held", d, N'(1) << 5);
    wrr(2'd3, '0);
    rd(2'd3, d); check("R6 write0", d, N'(1) << 5);
    wrr(2'd3, N'(1) << 5);
    rd(2'd3, d); check("R7 cleared", d, '0);
    check("R5 irq low", irq, 0);
    @(negedge clk);
    rd(2'd3, d); check("R7 next", d, N'(1) << 12);
    clear_all();

    // R4 masked source
    wrr(2'd1, N'(1) << 3);
    pulse(N'(1) << 3);
    rd(2'd2, d); check("R4 src set", d, N'(1) << 3);
    rd(2'd3, d); check("R4 int empty", d, '0);
    check("R4 irq", irq, 0);
    clear_all();

    // R8 NMI ignores mask
    wrr(2'd1, ALL);
    wrr(2'd0, N'(1) << 9);
    req = N'(1) << 9;
    @(negedge clk); req = '0;
    @(negedge clk);
    check("R8 nmi", nmi, 1);
    @(negedge clk);
    rd(2'd3, d); check("R8 not arbitrated", d, '0);
    wrr(2'd2, N'(1) << 9);
    check("R8 nmi cleared", nmi, 0);
    clear_all();

    // R9 two NMI bits
    wrr(2'd1, '0);
    wrr(2'd0, (N'(1) << 4) | (N'(1) << 15));
    rd(2'd0, d); check("R9 readback", d, (N'(1) << 4) | (N'(1) << 15));
    pulse(N'(1) << 15);
    check("R9 high bit no nmi", nmi, 0);
    rd(2'd3, d); check("R9 high bit irq", d, N'(1) << 15);
    pulse(N'(1) << 4);
    check("R9 low bit nmi", nmi, 1);
    clear_all();

    // R6 held request wins over clear
    wrr(2'd0, '0);
    req = N'(1) << 2;
    repeat (2) @(negedge clk);
    wrr(2'd2, N'(1) << 2);
    rd(2'd2, d); check("R6 held set", d, N'(1) << 2);
    clear_all();

    // random patterns
    for (int it = 0; it < 40; it++) begin
      pat = N'($urandom) & ALL;
      msk = N'($urandom) & ALL;
      case ($urandom % 3)
        0: md = '0;
        1: md = N'(1) << ($urandom % N);
        default: md = (N'(1) << ($urandom % N)) | (N'(1) << ($urandom % N));
      endcase
      wrr(2'd0, md);
      wrr(2'd1, msk);
      pulse(pat);
      ns = lowbit(md);
      rd(2'd2, d); check("R2 rand src", d, pat);
      rd(2'd3, d); check("R3 rand int", d, lowbit(pat & ~msk & ~ns));
      check("R5 rand irq", irq, (pat & ~msk & ~ns) != '0);
      check("R8 rand nmi", nmi, (pat & ns) != '0);
      clear_all();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule